// File: doc/BRIEF.md
# Low-Power Entry/Exit Handshake Register

This block is the host-facing control point for moving a device into and out of a low-power state. The host writes a control register that holds a sleep-request bit and a notify bit. A sequencer then carries out the move over a fixed number of clock cycles. While the move is under way, the block shows a busy flag in the same register. A request that needs no move completes at once and never shows busy, so a host that reads busy as clear after its write can go on without waiting.

The completion of a move raises a done status bit, but only when notify was set with the request. An exit request always sets notify. While the device sits in low power, the block watches a peer "data pending" input. If that input is high, it raises a wake status bit so the host can start a resume. Both status bits are write-one-to-clear. Each one has its own enable bit, and the interrupt output is the OR of the status bits whose enables are set. The current low-power state also drives an output pin for the power controller.

Register map (address: contents):

- 0, control: bit 0 sleep request, bit 1 notify, bit 2 busy (read only), bit 3 low-power state (read only).
- 1, status: bit 0 done, bit 1 wake.
- 2, enable: bit 0 done enable, bit 1 wake enable.
- 3: unused.

All other bits read as zero.

Top module: `lp_handshake_reg`

## Requirements
- R1: After reset, every register reads zero, `lp_state_o` is 0 and `irq_o` is 0.
- R2: A control write with bit 0 = 1 while the state is 0 and busy is 0 starts an entry. Busy (control bit 2) reads 1 for exactly LATENCY cycles after the write. At the end of that window, the state (control bit 3) and `lp_state_o` become 1 and busy returns to 0.
- R3: A control write with bit 0 = 0 while the state is 1 and busy is 0 starts an exit. It behaves the same way as R2, and the state returns to 0 at its end.
- R4: An accepted exit request stores notify (control bit 1) as 1, whatever value bit 1 held in the write.
- R5: When a move completes, the done status bit (status bit 0) is set if and only if the stored notify bit is 1.
- R6: An accepted control write whose bit 0 equals the current state never raises busy, never changes the state and never sets done. It still stores the written bit 0 and bit 1.
- R7: A control write that arrives while busy is 1 is ignored. The control register reads back unchanged, and the move in progress finishes toward its original target.
- R8: The wake status bit (status bit 1) is set in every cycle in which the state is 1 and `peer_pending_i` is 1. It is never set while the state is 0.
- R9: Writing 1 to a status bit clears it, and writing 0 leaves it as it is. If a set and a clear fall in the same cycle, the set wins.
- R10: `irq_o` equals the OR of (status bit AND enable bit) over both bits. The enable register holds the last value written to its bits 1:0.
- R11: Reads at address 3 return zero, and writes to address 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data for `reg_addr_i`, combinational |
| peer_pending_i | input | 1 | Peer has data waiting |
| lp_state_o | output | 1 | Current low-power state |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with LATENCY = 6, DATA_W = 8 and ADDR_W = 2. A six-cycle window is short enough that a random write stream often lands control writes inside a move, which exercises the ignore rule of R7. It also lands status clears on the very cycle a completion or a wake sets a bit, which exercises the set-wins rule of R9. A bench model that mirrors the requirements is compared with every register read and with both outputs in every cycle. Directed sequences cover the exact busy length, the forced notify on exit, redundant requests and wake gating.

// File: rtl/lph_pkg.sv
// Shared definitions for the low-power handshake register.
// Assumes a register port of at least 2 address bits and 4 data bits.
package lph_pkg;

    // Register addresses
    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_STAT = 2'd1,
        SEL_IE   = 2'd2,
        SEL_NONE = 2'd3
    } lph_sel_e;

    // Control register bit positions
    localparam int unsigned CTRL_SLEEP  = 0;
    localparam int unsigned CTRL_NOTIFY = 1;
    localparam int unsigned CTRL_BUSY   = 2;
    localparam int unsigned CTRL_STATE  = 3;

    // Status / enable bit positions
    localparam int unsigned SRC_DONE = 0;
    localparam int unsigned SRC_WAKE = 1;
    localparam int unsigned N_SRC    = 2;

endpackage

// File: rtl/lph_seq.sv
// Transition sequencer: carries out a state move over LATENCY cycles.
// Assumes start_i is only raised while busy_o is low. With LATENCY == 0
// the state moves on the accepting edge and busy_o never rises.
module lph_seq #(
    parameter int unsigned LATENCY = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic target_i,
    output logic busy_o,
    output logic lp_o,
    output logic done_o
);
    localparam int unsigned CNT_W = (LATENCY > 1) ? $clog2(LATENCY) : 1;

    generate
        if (LATENCY == 0) begin : g_instant
            logic lp_q;

            // Immediate state update on an accepted move
            always_ff @(posedge clk) begin
                if (!rst_n)       lp_q <= 1'b0;
                else if (start_i) lp_q <= target_i;
            end

            assign busy_o = 1'b0;
            assign lp_o   = lp_q;
            assign done_o = start_i;
        end else begin : g_timed
            logic [CNT_W-1:0] cnt_q;
            logic             busy_q;
            logic             tgt_q;
            logic             lp_q;

            // Count down the move window and commit the target at its end
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt_q  <= '0;
                    busy_q <= 1'b0;
                    tgt_q  <= 1'b0;
                    lp_q   <= 1'b0;
                end else if (busy_q) begin
                    if (cnt_q == '0) begin
                        busy_q <= 1'b0;
                        lp_q   <= tgt_q;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end else if (start_i) begin
                    busy_q <= 1'b1;
                    cnt_q  <= CNT_W'(LATENCY - 1);
                    tgt_q  <= target_i;
                end
            end

            assign busy_o = busy_q;
            assign lp_o   = lp_q;
            assign done_o = busy_q && (cnt_q == '0);
        end
    endgenerate

endmodule

// File: rtl/lph_ctrl.sv
// Control register: holds the sleep request and notify bits. It accepts
// a write only when no move is in flight and forces notify on exit.
// Assumes lp_i and busy_i come from the sequencer.
module lph_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_ctrl_i,
    input  logic wd_sleep_i,
    input  logic wd_notify_i,
    input  logic busy_i,
    input  logic lp_i,
    output logic req_o,
    output logic notify_o,
    output logic start_o,
    output logic target_o
);
    logic req_q;
    logic notify_q;
    logic accept;

    assign accept = wr_ctrl_i && !busy_i;

    // Capture request bits on an accepted write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q    <= 1'b0;
            notify_q <= 1'b0;
        end else if (accept) begin
            req_q    <= wd_sleep_i;
            notify_q <= wd_notify_i | (lp_i & ~wd_sleep_i);
        end
    end

    assign req_o    = req_q;
    assign notify_o = notify_q;
    assign start_o  = accept && (wd_sleep_i != lp_i);
    assign target_o = wd_sleep_i;

endmodule

// File: rtl/lph_status.sv
// Sticky status bits with write-one-to-clear, per-bit enables and the
// combined interrupt. A set wins over a clear in the same cycle.
module lph_status #(
    parameter int unsigned NSRC = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_i,
    input  logic            wr_stat_i,
    input  logic            wr_ie_i,
    input  logic [NSRC-1:0] wd_i,
    output logic [NSRC-1:0] stat_o,
    output logic [NSRC-1:0] ie_o,
    output logic            irq_o
);
    logic [NSRC-1:0] stat_q;
    logic [NSRC-1:0] ie_q;

    generate
        for (genvar g = 0; g < NSRC; g++) begin : g_bit
            // One sticky status bit
            always_ff @(posedge clk) begin
                if (!rst_n) stat_q[g] <= 1'b0;
                else        stat_q[g] <= set_i[g] | (stat_q[g] & ~(wr_stat_i & wd_i[g]));
            end
        end
    endgenerate

    // Enable mask register
    always_ff @(posedge clk) begin
        if (!rst_n)       ie_q <= '0;
        else if (wr_ie_i) ie_q <= wd_i;
    end

    assign stat_o = stat_q;
    assign ie_o   = ie_q;
    assign irq_o  = |(stat_q & ie_q);

endmodule

// File: rtl/lp_handshake_reg.sv
// Top of the low-power handshake register. It decodes the register port,
// ties the control, sequencer and status blocks together and builds the
// read mux. Assumes DATA_W >= 4 and ADDR_W >= 2; upper address bits must
// be zero for a register hit.
module lp_handshake_reg #(
    parameter int unsigned ADDR_W  = 2,
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned LATENCY = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    input  logic              peer_pending_i,
    output logic              lp_state_o,
    output logic              irq_o
);
    import lph_pkg::*;

    logic hit_ctrl, hit_stat, hit_ie;
    logic wr_ctrl, wr_stat, wr_ie;
    logic busy_w, lp_w, done_w;
    logic req_q, notify_q, start_w, target_w;
    logic [N_SRC-1:0] set_w, stat_w, ie_w;
    logic unused_wdata;

    assign hit_ctrl = (reg_addr_i == ADDR_W'(SEL_CTRL));
    assign hit_stat = (reg_addr_i == ADDR_W'(SEL_STAT));
    assign hit_ie   = (reg_addr_i == ADDR_W'(SEL_IE));
    assign wr_ctrl  = reg_wr_i && hit_ctrl;
    assign wr_stat  = reg_wr_i && hit_stat;
    assign wr_ie    = reg_wr_i && hit_ie;
    assign unused_wdata = ^reg_wdata_i[DATA_W-1:2];

    lph_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_ctrl_i  (wr_ctrl),
        .wd_sleep_i (reg_wdata_i[CTRL_SLEEP]),
        .wd_notify_i(reg_wdata_i[CTRL_NOTIFY]),
        .busy_i     (busy_w),
        .lp_i       (lp_w),
        .req_o      (req_q),
        .notify_o   (notify_q),
        .start_o    (start_w),
        .target_o   (target_w)
    );

    lph_seq #(.LATENCY(LATENCY)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_w),
        .target_i(target_w),
        .busy_o  (busy_w),
        .lp_o    (lp_w),
        .done_o  (done_w)
    );

    assign set_w[SRC_DONE] = done_w && notify_q;
    assign set_w[SRC_WAKE] = lp_w && peer_pending_i;

    lph_status #(.NSRC(N_SRC)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (set_w),
        .wr_stat_i(wr_stat),
        .wr_ie_i  (wr_ie),
        .wd_i     (reg_wdata_i[N_SRC-1:0]),
        .stat_o   (stat_w),
        .ie_o     (ie_w),
        .irq_o    (irq_o)
    );

    // Read mux over the register map
    always_comb begin
        reg_rdata_o = '0;
        if (hit_ctrl) begin
            reg_rdata_o[CTRL_SLEEP]  = req_q;
            reg_rdata_o[CTRL_NOTIFY] = notify_q;
            reg_rdata_o[CTRL_BUSY]   = busy_w;
            reg_rdata_o[CTRL_STATE]  = lp_w;
        end else if (hit_stat) begin
            reg_rdata_o[N_SRC-1:0] = stat_w;
        end else if (hit_ie) begin
            reg_rdata_o[N_SRC-1:0] = ie_w;
        end
    end

    assign lp_state_o = lp_w;

endmodule

// File: rtl/lph_checker.sv
// Property checker for lp_handshake_reg, attached with bind below.
module lph_checker #(
    parameter int unsigned LATENCY = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_ctrl,
    input logic       wd_sleep,
    input logic       busy,
    input logic       lp,
    input logic       notify,
    input logic       req,
    input logic [1:0] stat,
    input logic [1:0] ie,
    input logic       peer,
    input logic       irq
);
    // R6: a request matching the state never raises busy
    p_redundant_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !busy && (wd_sleep == lp)) |=> !busy);

    // R7: control contents hold while a move is in flight
    p_ignore_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && busy) |=> ($stable(req) && $stable(notify)));

    // R4: exit request stores notify set
    p_exit_notify_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !busy && lp && !wd_sleep) |=> notify);

    // R8: wake only rises from peer data in low power
    p_wake_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat[1]) |-> $past(lp && peer));

    // R10: no interrupt with all enables off
    p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ie == 2'b00) |-> !irq);

    generate
        if (LATENCY > 0) begin : g_timed
            int unsigned busy_len;

            // Length of the current busy window
            always_ff @(posedge clk) begin
                if (!rst_n)    busy_len <= 0;
                else if (busy) busy_len <= busy_len + 1;
                else           busy_len <= 0;
            end

            // R2: busy window is exactly LATENCY cycles
            p_busy_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(busy) |-> (busy_len == LATENCY));

            // R3: state only moves as busy ends
            p_state_move_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (lp != $past(lp)) |-> $fell(busy));

            // R5: done rises only at completion with notify stored
            p_done_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(stat[0]) |-> ($fell(busy) && notify));
        end
    endgenerate

endmodule

bind lp_handshake_reg lph_checker #(.LATENCY(LATENCY)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_ctrl (wr_ctrl),
    .wd_sleep(reg_wdata_i[0]),
    .busy    (busy_w),
    .lp      (lp_w),
    .notify  (notify_q),
    .req     (req_q),
    .stat    (stat_w),
    .ie      (ie_w),
    .peer    (peer_pending_i),
    .irq     (irq_o)
);

// File: tb/lp_handshake_reg_tb.sv
module lp_handshake_reg_tb;
    localparam int LAT = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       peer = 1'b0;
    logic       lp_out;
    logic       irq;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    // Model state, built from the requirements
    logic m_lp, m_busy, m_tgt, m_req, m_not, m_done, m_wake;
    logic [1:0] m_ie;
    int m_cnt;

    lp_handshake_reg #(.ADDR_W(2), .DATA_W(8), .LATENCY(LAT)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_i(wr), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .peer_pending_i(peer),
        .lp_state_o(lp_out), .irq_o(irq)
    );

    always #5 clk = ~clk;

    function automatic logic [7:0] exp_rd(input logic [1:0] a);
        case (a)
            2'd0: return {4'b0, m_lp, m_busy, m_not, m_req};
            2'd1: return {6'b0, m_wake, m_done};
            2'd2: return {6'b0, m_ie};
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_lp = 0; m_busy = 0; m_tgt = 0; m_req = 0; m_not = 0;
        m_done = 0; m_wake = 0; m_ie = 0; m_cnt = 0;
    endtask

    task automatic model_step(input logic w, input logic [1:0] a, input logic [7:0] d, input logic pe);
        logic set_done, set_wake;
        set_done = m_busy && (m_cnt == 0) && m_not;
        set_wake = m_lp && pe;
        if (w && a == 2'd1) begin
            if (d[0]) m_done = 0;
            if (d[1]) m_wake = 0;
        end
        if (set_done) m_done = 1;
        if (set_wake) m_wake = 1;
        if (w && a == 2'd2) m_ie = d[1:0];
        if (m_busy) begin
            if (m_cnt == 0) begin
                m_busy = 0;
                m_lp   = m_tgt;
            end else begin
                m_cnt--;
            end
        end else if (w && a == 2'd0) begin
            m_not = d[1] | (m_lp & ~d[0]);
            m_req = d[0];
            if (d[0] != m_lp) begin
                m_busy = 1;
                m_cnt  = LAT - 1;
                m_tgt  = d[0];
            end
        end
    endtask

    // One cycle: drive, compare the current state, then advance the model
    task automatic step(input logic w, input logic [1:0] a, input logic [7:0] d,
                        input logic pe, input string tag, output logic [7:0] rd);
        logic [7:0] e;
        @(negedge clk);
        wr = w; addr = a; wdata = d; peer = pe;
        #1;
        rd = rdata;
        e = exp_rd(a);
        check(rdata == e, tag, rdata, e);
        check(irq == |({m_wake, m_done} & m_ie), "R10 irq", irq, |({m_wake, m_done} & m_ie));
        check(lp_out == m_lp, "R2 lp_state_o", lp_out, m_lp);
        model_step(w, a, d, pe);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        int nb;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state, R11 unused address
        step(0, 2'd0, 8'h00, 0, "R1 ctrl", rd);
        step(0, 2'd1, 8'h00, 0, "R1 stat", rd);
        step(0, 2'd2, 8'h00, 0, "R1 ie", rd);
        step(1, 2'd3, 8'hFF, 0, "R11 write", rd);
        step(0, 2'd3, 8'h00, 0, "R11 read", rd);
        step(0, 2'd2, 8'h00, 0, "R11 no effect", rd);

        // R10 enables
        step(1, 2'd2, 8'h03, 0, "R10 ie write", rd);

        // R2 entry with notify, busy window length
        step(1, 2'd0, 8'h03, 0, "R2 enter", rd);
        nb = 0;
        for (int i = 0; i < LAT + 2; i++) begin
            step(0, 2'd0, 8'h00, 0, "R2 busy", rd);
            nb += rd[2];
        end
        check(nb == LAT, "R2 busy length", nb, LAT);
        check(lp_out == 1'b1, "R2 entered", lp_out, 1);
        step(0, 2'd1, 8'h00, 0, "R5 done set", rd);
        check(rd[0] == 1'b1, "R5 done with notify", rd[0], 1);

        // R9 write-zero keeps, write-one clears
        step(1, 2'd1, 8'h00, 0, "R9 w0", rd);
        step(1, 2'd1, 8'h01, 0, "R9 w1c", rd);
        step(0, 2'd1, 8'h00, 0, "R9 cleared", rd);
        check(rd[0] == 1'b0, "R9 done cleared", rd[0], 0);

        // R8 wake in low power
        step(0, 2'd1, 8'h00, 1, "R8 peer", rd);
        step(0, 2'd1, 8'h00, 0, "R8 wake", rd);
        check(rd[1] == 1'b1, "R8 wake set", rd[1], 1);
        step(1, 2'd1, 8'h02, 0, "R9 wake clr", rd);

        // R6 redundant entry
        step(1, 2'd0, 8'h01, 0, "R6 redundant", rd);
        step(0, 2'd0, 8'h00, 0, "R6 no busy", rd);
        check(rd[2] == 1'b0 && rd[3] == 1'b1, "R6 state held", rd, 8'h09);

        // R3/R4 exit with notify written 0; R7 write during busy
        step(1, 2'd0, 8'h00, 0, "R3 exit", rd);
        step(0, 2'd0, 8'h00, 0, "R4 notify", rd);
        check(rd[1] == 1'b1, "R4 notify forced", rd[1], 1);
        step(1, 2'd0, 8'h01, 0, "R7 ignored write", rd);
        step(0, 2'd0, 8'h00, 0, "R7 readback", rd);
        check(rd[0] == 1'b0 && rd[2] == 1'b1, "R7 ctrl unchanged", rd, 8'h0E);
        for (int i = 0; i < LAT; i++) step(0, 2'd0, 8'h00, 0, "R3 busy", rd);
        check(lp_out == 1'b0, "R3 exited", lp_out, 0);
        step(0, 2'd1, 8'h00, 0, "R5 exit done", rd);
        step(1, 2'd1, 8'h03, 0, "R9 clr all", rd);

        // R8 no wake when awake
        step(0, 2'd1, 8'h00, 1, "R8 awake peer", rd);
        step(0, 2'd1, 8'h00, 0, "R8 no wake", rd);
        check(rd[1] == 1'b0, "R8 wake gated", rd[1], 0);

        // R5 entry without notify
        step(1, 2'd0, 8'h01, 0, "R5 enter quiet", rd);
        for (int i = 0; i < LAT + 1; i++) step(0, 2'd1, 8'h00, 0, "R5 no done", rd);
        check(rd[0] == 1'b0, "R5 done absent", rd[0], 0);

        // Random traffic against the model
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 4000; i++) begin
            logic w;
            logic [1:0] a;
            w = ($urandom % 10) < 4;
            a = 2'($urandom % 4);
            step(w, a, 8'($urandom), ($urandom % 5) == 0,
                 (a == 2'd0) ? "R7 random ctrl" : (a == 2'd1) ? "R9 random stat" : "R10 random", rd);
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule